// File: doc/BRIEF.md
# Ticket-Ordered Shared Lock Arbiter

This block arbitrates one shared lock among a fixed set of requesting cores. Each requester drives three one-cycle request lines: wait-acquire, try-acquire and release. The block answers with a level showing that it owns the lock, a level showing that it is waiting in line, and one-cycle pulses that report a refused try and an illegal release.

The lock state is two modulo counters. One holds the ticket to be handed out next and the other holds the ticket now being served. An acquiring requester takes the value of the issue counter as its ticket, and that counter advances past it in the same cycle. The requester whose stored ticket equals the serving counter owns the lock. A release by the owner advances the serving counter by one, so the lock always passes to the oldest waiter and no waiter can be passed over.

A try-acquire never waits. It succeeds only when no ticket is outstanding and no lower-numbered requester takes a ticket in the same cycle. Otherwise it is refused at once and consumes no ticket.

Top module: `ticket_lock_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, `own` and `wait_q` are all low, `try_nak` is low and `rel_bad` is low.
- R2: An `acq_req[i]` from a requester that neither owns nor waits takes a ticket, and from the next cycle that requester shows either `own[i]` or `wait_q[i]`. An `acq_req[i]` from a requester that already owns or waits has no effect.
- R3: `own[i]` is high for exactly the requester whose ticket equals the serving counter, and at most one bit of `own` is ever high.
- R4: A release by the owner (`rel_req[i]` with `own[i]` high) drops `own[i]` in the next cycle and hands the lock to the waiter that took its ticket earliest.
- R5: Requesters that take tickets in the same cycle receive consecutive tickets in ascending index order, so bit 0 is served first.
- R6: A `try_req[i]` from an idle requester, without `acq_req[i]`, while no ticket is outstanding and no lower index takes a ticket in that cycle, makes `own[i]` high in the next cycle.
- R7: Any other `try_req[i]` that is not paired with `acq_req[i]` pulses `try_nak[i]` for one cycle in the next cycle and consumes no ticket.
- R8: A `rel_req[i]` while `own[i]` is low is ignored (lock ownership and the queue are unchanged) and pulses `rel_bad` for one cycle in the next cycle.
- R9: Both counters wrap modulo 2^TKT_W. Ordering stays correct across the wrap, and the number of requesters must not exceed 2^TKT_W − 1.
- R10: A waiting requester stays waiting until it becomes the owner; it is never dropped from the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_req | input | N_REQ | Per-requester wait-acquire request, one cycle |
| try_req | input | N_REQ | Per-requester try-acquire request, one cycle |
| rel_req | input | N_REQ | Per-requester release request, one cycle |
| own | output | N_REQ | Requester currently owns the lock |
| wait_q | output | N_REQ | Requester holds a ticket and is waiting |
| try_nak | output | N_REQ | One-cycle pulse: try-acquire refused |
| rel_bad | output | 1 | One-cycle pulse: release from a non-owner |

## Verification
The assertions take for granted that each requester asks for at most one ticket at a time. The block enforces this itself by ignoring acquires from busy requesters, so the number of outstanding tickets is bounded by N_REQ and never aliases under the modulo counters. They also assume that the request lines are clean, synchronous levels sampled at the clock edge. The stimulus drives every request only at the falling edge. It deliberately mixes acquires from busy requesters, releases from non-owners and tries on a held lock, and it never relies on anything outside the port contract. The random phase runs long enough for the ticket counters to wrap many times.

// File: rtl/tkl_pkg.sv
package tkl_pkg;

  // modulo-2^w addition used for ticket arithmetic
  function automatic int unsigned ring_add(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned w);
    ring_add = (a + b) & ((32'd1 << w) - 32'd1);
  endfunction

  // number of tickets still outstanding between serving and next
  function automatic int unsigned ring_span(input int unsigned nxt,
                                            input int unsigned srv,
                                            input int unsigned w);
    ring_span = (nxt - srv) & ((32'd1 << w) - 32'd1);
  endfunction

  // ticket-capacity check: N requesters need N <= 2^w - 1
  function automatic bit width_ok(input int unsigned n, input int unsigned w);
    width_ok = (n <= ((32'd1 << w) - 32'd1));
  endfunction

endpackage

// File: rtl/tkl_issue.sv
module tkl_issue #(
  parameter int N_REQ = 4,
  parameter int TKT_W = 4,
  localparam int CW   = $clog2(N_REQ + 1)
) (
  input  logic [N_REQ-1:0]             idle,
  input  logic [N_REQ-1:0]             acq,
  input  logic [N_REQ-1:0]             try_in,
  input  logic                         lock_free,
  output logic [N_REQ-1:0]             take,
  output logic [N_REQ-1:0]             fail,
  output logic [N_REQ-1:0][TKT_W-1:0]  offset,
  output logic [CW-1:0]                take_cnt
);

  always_comb begin
    int cnt;
    cnt = 0;
    for (int i = 0; i < N_REQ; i++) begin
      take[i]   = 1'b0;
      fail[i]   = 1'b0;
      offset[i] = TKT_W'(cnt);
      if (idle[i] && acq[i]) begin
        take[i] = 1'b1;
      end else if (idle[i] && try_in[i] && lock_free && cnt == 0) begin
        take[i] = 1'b1;
      end else if (try_in[i] && !acq[i]) begin
        fail[i] = 1'b1;
      end
      if (take[i]) cnt = cnt + 1;
    end
    take_cnt = CW'(cnt);
  end

endmodule

// File: rtl/tkl_slot.sv
module tkl_slot #(
  parameter int TKT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TKT_W-1:0] tkt_in,
  input  logic             clear,
  input  logic [TKT_W-1:0] serving,
  output logic             valid,
  output logic             held,
  output logic             queued
);

  logic [TKT_W-1:0] tkt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tkt_q <= '0;
    end else if (load) begin
      valid <= 1'b1;
      tkt_q <= tkt_in;
    end else if (clear) begin
      valid <= 1'b0;
    end
  end

  assign held   = valid && (tkt_q == serving);
  assign queued = valid && (tkt_q != serving);

endmodule

// File: rtl/tkl_count.sv
module tkl_count #(
  parameter int N_REQ = 4,
  parameter int TKT_W = 4,
  localparam int CW   = $clog2(N_REQ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    take_cnt,
  input  logic             advance,
  output logic [TKT_W-1:0] next_tkt,
  output logic [TKT_W-1:0] serving,
  output logic             lock_free
);
  import tkl_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_tkt <= '0;
      serving  <= '0;
    end else begin
      next_tkt <= TKT_W'(ring_add(int'(next_tkt), int'(take_cnt), TKT_W));
      if (advance) serving <= TKT_W'(ring_add(int'(serving), 1, TKT_W));
    end
  end

  assign lock_free = (next_tkt == serving);

endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit #(
  parameter int N_REQ = 4,
  parameter int TKT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] acq_req,
  input  logic [N_REQ-1:0] try_req,
  input  logic [N_REQ-1:0] rel_req,
  output logic [N_REQ-1:0] own,
  output logic [N_REQ-1:0] wait_q,
  output logic [N_REQ-1:0] try_nak,
  output logic             rel_bad
);
  import tkl_pkg::*;

  localparam int CW = $clog2(N_REQ + 1);

  generate
    if (!width_ok(N_REQ, TKT_W)) begin : g_bad_width
      $error("ticket width too small for requester count");
    end
  endgenerate

  logic [N_REQ-1:0]            valid_v;
  logic [N_REQ-1:0]            take_v;
  logic [N_REQ-1:0]            fail_v;
  logic [N_REQ-1:0][TKT_W-1:0] offs_v;
  logic [CW-1:0]               take_cnt;
  logic [TKT_W-1:0]            next_tkt;
  logic [TKT_W-1:0]            serving;
  logic                        lock_free;
  logic [N_REQ-1:0]            rel_ok_v;
  logic                        rel_err_d;
  logic                        advance;

  assign rel_ok_v  = rel_req & own;
  assign advance   = |rel_ok_v;
  assign rel_err_d = |(rel_req & ~own);

  tkl_issue #(.N_REQ(N_REQ), .TKT_W(TKT_W)) i_issue (
    .idle      (~valid_v),
    .acq       (acq_req),
    .try_in    (try_req),
    .lock_free (lock_free),
    .take      (take_v),
    .fail      (fail_v),
    .offset    (offs_v),
    .take_cnt  (take_cnt)
  );

  tkl_count #(.N_REQ(N_REQ), .TKT_W(TKT_W)) i_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_cnt  (take_cnt),
    .advance   (advance),
    .next_tkt  (next_tkt),
    .serving   (serving),
    .lock_free (lock_free)
  );

  generate
    for (genvar g = 0; g < N_REQ; g++) begin : g_slot
      logic [TKT_W-1:0] tkt_new;
      assign tkt_new = TKT_W'(ring_add(int'(next_tkt), int'(offs_v[g]), TKT_W));
      tkl_slot #(.TKT_W(TKT_W)) i_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take_v[g]),
        .tkt_in  (tkt_new),
        .clear   (rel_ok_v[g]),
        .serving (serving),
        .valid   (valid_v[g]),
        .held    (own[g]),
        .queued  (wait_q[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      try_nak <= '0;
      rel_bad <= 1'b0;
    end else begin
      try_nak <= fail_v;
      rel_bad <= rel_err_d;
    end
  end

endmodule

// File: rtl/tkl_chk.sv
module tkl_chk #(
  parameter int N_REQ = 4,
  parameter int TKT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] rel_req,
  input logic [N_REQ-1:0] own,
  input logic [N_REQ-1:0] wait_q,
  input logic             rel_bad,
  input logic [TKT_W-1:0] next_tkt,
  input logic [TKT_W-1:0] serving
);

  logic [TKT_W-1:0] span;
  assign span = TKT_W'(next_tkt - serving);

  // R3
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own));

  // R8
  bad_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_bad |-> $past(|(rel_req & ~own)));

  // R4
  serve_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serving != $past(serving)) |->
      ((serving == TKT_W'($past(serving) + 1'b1)) && $past(|(rel_req & own))));

  // R9
  span_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(span) <= N_REQ);

  generate
    for (genvar g = 0; g < N_REQ; g++) begin : g_wait
      // R10
      keep_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q[g] |=> (wait_q[g] || own[g]));
    end
  endgenerate

endmodule

bind ticket_lock_unit tkl_chk #(.N_REQ(N_REQ), .TKT_W(TKT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rel_req  (rel_req),
  .own      (own),
  .wait_q   (wait_q),
  .rel_bad  (rel_bad),
  .next_tkt (next_tkt),
  .serving  (serving)
);

// File: tb/test_ticket_lock_unit.sv
module test_ticket_lock_unit;
  localparam int N = 4;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] acq_req = '0, try_req = '0, rel_req = '0;
  logic [N-1:0] own, wait_q, try_nak;
  logic         rel_bad;

  int total = 0;
  int bad = 0;
  int grants = 0;
  int q[$];
  logic [N-1:0] e_own = '0, e_wait = '0, e_nak = '0;
  logic         e_bad = 1'b0;
  bit           done = 0;

  always #2.5 clk = ~clk;

  ticket_lock_unit #(.N_REQ(N), .TKT_W(W)) i_ticket_lock_unit (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .try_req(try_req),
    .rel_req(rel_req), .own(own), .wait_q(wait_q), .try_nak(try_nak),
    .rel_bad(rel_bad)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit in_q(input int id);
    foreach (q[k]) if (q[k] == id) return 1;
    return 0;
  endfunction

  // behavioural model: queue of requester ids, front owns the lock
  task automatic model(input logic [N-1:0] a, input logic [N-1:0] t,
                       input logic [N-1:0] r);
    int  front;
    bit  busy[N];
    bit  took;
    bit  was_empty;
    front = (q.size() > 0) ? q[0] : -1;
    was_empty = (q.size() == 0);
    for (int i = 0; i < N; i++) busy[i] = in_q(i);
    e_bad = 1'b0;
    for (int i = 0; i < N; i++) if (r[i] && i != front) e_bad = 1'b1;
    e_nak = '0;
    took = 0;
    for (int i = 0; i < N; i++) begin
      if (!busy[i] && a[i]) begin
        q.push_back(i); took = 1;
      end else if (!busy[i] && t[i] && was_empty && !took) begin
        q.push_back(i); took = 1;
      end else if (t[i] && !a[i]) begin
        e_nak[i] = 1'b1;
      end
    end
    if (front >= 0 && r[front]) void'(q.pop_front());
    e_own = '0; e_wait = '0;
    foreach (q[k]) begin
      if (k == 0) e_own[q[k]] = 1'b1;
      else        e_wait[q[k]] = 1'b1;
    end
    if (q.size() > 0 && q[0] != front) grants++;
  endtask

  task automatic step(input logic [N-1:0] a, input logic [N-1:0] t,
                      input logic [N-1:0] r);
    acq_req = a; try_req = t; rel_req = r;
    model(a, t, r);
    @(negedge clk);
    acq_req = '0; try_req = '0; rel_req = '0;
    chk(own == e_own, "R3 own", own, e_own);
    chk(wait_q == e_wait, "R10 wait_q", wait_q, e_wait);
    chk(try_nak == e_nak, "R7 try_nak", try_nak, e_nak);
    chk(rel_bad == e_bad, "R8 rel_bad", rel_bad, e_bad);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(own == '0 && wait_q == '0, "R1 levels in reset", {own, wait_q}, 0);
    chk(try_nak == '0 && !rel_bad, "R1 pulses in reset", {try_nak, rel_bad}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(own == '0 && wait_q == '0 && try_nak == '0 && !rel_bad,
        "R1 after reset", {own, wait_q, try_nak, rel_bad}, 0);

    // all four acquire together: bit 0 first
    step(4'b1111, '0, '0);
    chk(own == 4'b0001, "R5 lowest index owns", own, 4'b0001);
    chk(wait_q == 4'b1110, "R2 others wait", wait_q, 4'b1110);
    step(4'b0001, '0, '0);                 // acquire by owner ignored
    chk(own == 4'b0001 && wait_q == 4'b1110, "R2 busy acquire ignored",
        {own, wait_q}, {4'b0001, 4'b1110});
    step('0, '0, 4'b0001);
    chk(own == 4'b0010, "R4 handover to next", own, 4'b0010);
    step('0, '0, 4'b0100);                 // non-owner release
    chk(rel_bad == 1'b1, "R8 error pulse", rel_bad, 1);
    chk(own == 4'b0010 && wait_q == 4'b1100, "R8 state unchanged",
        {own, wait_q}, {4'b0010, 4'b1100});
    step('0, '0, '0);
    chk(rel_bad == 1'b0, "R8 pulse one cycle", rel_bad, 0);
    step(4'b0001, '0, 4'b0010);            // 0 rejoins at tail
    step('0, '0, 4'b0100);
    chk(own == 4'b1000, "R4 arrival order", own, 4'b1000);
    step('0, '0, 4'b1000);
    chk(own == 4'b0001, "R4 rejoined requester last", own, 4'b0001);
    step('0, '0, 4'b0001);

    // try-lock cases
    step('0, 4'b0100, '0);
    chk(own == 4'b0100, "R6 try on free lock", own, 4'b0100);
    step('0, 4'b0010, '0);
    chk(try_nak == 4'b0010 && own == 4'b0100, "R7 try on held lock",
        {try_nak, own}, {4'b0010, 4'b0100});
    step('0, '0, 4'b0100);
    step(4'b0010, 4'b1000, '0);
    chk(own == 4'b0010 && try_nak == 4'b1000, "R7 lower acquirer wins",
        {own, try_nak}, {4'b0010, 4'b1000});
    step('0, '0, 4'b0010);
    chk(own == '0 && wait_q == '0, "R7 refused try took no ticket",
        {own, wait_q}, 0);

    // random traffic, counters wrap many times
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] a, t, r;
      a = N'($urandom) & N'($urandom);
      t = N'($urandom) & N'($urandom);
      r = '0;
      if (q.size() > 0 && ($urandom % 3) == 0) r[q[0]] = 1'b1;
      if (($urandom % 16) == 0) r = r | N'(1 << ($urandom % N));
      step(a, t, r);
    end
    chk(grants > 4 * (1 << W), "R9 ordering across wrap", grants, 4 * (1 << W));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule